// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the state machine that steps a small microcontroller core between its three slow-clock power states: a running state on the divided watch clock (subactive), a halted-CPU state with the peripherals still clocked (subsleep), and a deep state where only the watch timer keeps running (watch). It runs on the watch clock. It decodes sleep requests from the CPU against three configuration bits, and it qualifies wake-interrupt requests against their enable bits, the global interrupt mask and the state being left. From the current state it produces the CPU, peripheral and watch-timer clock enables.

In subactive the CPU does not get a derived clock. Instead the CPU clock enable is a one-cycle pulse that repeats every 2, 4 or 8 watch-clock cycles, as set by a 2-bit divider select. When the reset pin is low the block is forced into a separate reset state, ACTIVE. Leaving ACTIVE toward the low-power states is handled elsewhere, so a test-only load port can place the sequencer directly in any state.

Top module: `lpm_seq`

## Requirements
- R1: While `rst_pin_n` is low at a rising clock edge, the next state is ACTIVE (`mode` = 0), and `illegal_sleep` is 0 afterwards. In ACTIVE, sleep requests and wake requests do not change `mode`.
- R2: In watch (`mode` = 3) with `cfg_lson` = 1, a request from the restricted wake set moves the block to subactive (`mode` = 1). A request counts only if its enable bit is 1 and `irq_mask` is 0. The restricted set is `wake_req` bits 0..11: timer A = 0, timer F = 1, timer G = 2, IRQ0 = 3, keyboard wake lines 0..7 = bits 4..11. The request is registered at the first rising edge and `mode` changes at the second.
- R3: In watch, requests on the extended-only bits 12..18 (timer C = 12, event counter = 13, serial port = 14, event-counter interrupt = 15, IRQ4 = 16, IRQ3 = 17, IRQ1 = 18) are ignored. With `cfg_lson` = 0, every wake request is ignored in watch.
- R4: In subsleep (`mode` = 2), a qualified request on any of the 19 `wake_req` bits moves the block to subactive, with the same two-edge timing as R2.
- R5: No wake happens while `irq_mask` is 1, and none happens from a source whose `wake_en` bit is 0.
- R6: In subactive, a `sleep_req` with `cfg_stby` = 1 and `cfg_tmsrc` = 1 moves the block to watch at the rising edge that samples the request.
- R7: In subactive, a `sleep_req` with `cfg_stby` = 0, `cfg_lson` = 1 and `cfg_tmsrc` = 1 moves the block to subsleep at the rising edge that samples the request.
- R8: In subactive, a `sleep_req` that matches neither R6 nor R7 leaves the block in subactive and raises `illegal_sleep` for exactly the one cycle after the sampling edge.
- R9: In subactive, `cpu_clk_en` pulses once every 8, 4 or 2 cycles for `cfg_div` = 00, 01 or 1x. The first pulse comes in the cycle (ratio - 1) after entry. `cfg_div` is captured into `div_sel` at each edge in ACTIVE or subactive.
- R10: Clock enables by state: ACTIVE gives cpu=1, per=1. Subsleep gives cpu=0, per=1. Watch gives cpu=0, per=0. The watch-timer enable is 1 in every state.
- R11: Pulling `rst_pin_n` low in subactive (or any low-power state) returns the block to ACTIVE at the next edge, and it holds ACTIVE while the pin stays low, whatever the other inputs do.
- R12: When `rst_pin_n` is high, `tst_load` = 1 puts `tst_mode` into the state at the next edge, overriding sleep and wake decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watch clock |
| rst_pin_n | input | 1 | Reset pin, active low, sampled synchronously |
| sleep_req | input | 1 | One-cycle sleep request strobe from the CPU |
| cfg_stby | input | 1 | Standby select |
| cfg_lson | input | 1 | Low-speed-on |
| cfg_tmsrc | input | 1 | Timer clock-source select |
| cfg_div | input | 2 | Subactive divider select (00 /8, 01 /4, 1x /2) |
| wake_req | input | 19 | Wake-interrupt requests |
| wake_en | input | 19 | Per-source wake enables |
| irq_mask | input | 1 | Global interrupt mask (1 = masked) |
| tst_load | input | 1 | Test-only state load strobe |
| tst_mode | input | 2 | State written by the test load |
| mode | output | 2 | Current state: 0 ACTIVE, 1 subactive, 2 subsleep, 3 watch |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wtmr_clk_en | output | 1 | Watch-timer clock enable |
| div_sel | output | 2 | Captured divider select in use |
| illegal_sleep | output | 1 | One-cycle flag for an undecodable sleep request |

## Verification
A sleep decision shows up in `mode` one rising edge after the request is driven, and `illegal_sleep` is high for that one following cycle only. A wake decision takes two edges, one for the input register and one for the state register, so the bench checks that `mode` has not changed after the first edge and has changed after the second. Divider pulses are counted over a window of 24 cycles starting in the first cycle of subactive, and the first pulse must fall in cycle ratio - 1. All stimulus changes on the falling clock edge and every sample is taken on a falling edge, so each expected value lines up with a whole number of rising edges.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    // Wake source layout
    localparam int BASE_SRC   = 4;                    // timer A, F, G, IRQ0
    localparam int KBD_LINES  = 8;                    // keyboard wake lines
    localparam int EXT_SRC    = 7;                    // subsleep-only sources
    localparam int WATCH_W    = BASE_SRC + KBD_LINES; // restricted set size
    localparam int WAKE_W     = WATCH_W + EXT_SRC;    // full vector width

    // Subclock divider
    localparam int DIV_MAX    = 8;
    localparam int DIV_CNT_W  = $clog2(DIV_MAX);

    typedef enum logic [1:0] {
        M_ACTIVE = 2'd0,
        M_SUBACT = 2'd1,
        M_SUBSLP = 2'd2,
        M_WATCH  = 2'd3
    } mode_e;

    typedef struct packed {
        logic cpu_full;
        logic cpu_div;
        logic per;
        logic wtmr;
    } clk_plan_t;

    function automatic logic [WAKE_W-1:0] wake_set_for(mode_e m);
        logic [WAKE_W-1:0] s;
        s = '0;
        for (int i = 0; i < WAKE_W; i++) begin
            if (m == M_SUBSLP)
                s[i] = 1'b1;
            else if (m == M_WATCH && i < WATCH_W)
                s[i] = 1'b1;
        end
        return s;
    endfunction

    function automatic logic [DIV_CNT_W-1:0] div_last(logic [1:0] code);
        logic [DIV_CNT_W-1:0] r;
        if (code[1])
            r = DIV_CNT_W'(1);
        else if (code[0])
            r = DIV_CNT_W'(3);
        else
            r = DIV_CNT_W'(DIV_MAX - 1);
        return r;
    endfunction

    function automatic clk_plan_t clocks_for(mode_e m);
        clk_plan_t c;
        c.wtmr = 1'b1;
        unique case (m)
            M_ACTIVE: begin c.cpu_full = 1'b1; c.cpu_div = 1'b0; c.per = 1'b1; end
            M_SUBACT: begin c.cpu_full = 1'b0; c.cpu_div = 1'b1; c.per = 1'b1; end
            M_SUBSLP: begin c.cpu_full = 1'b0; c.cpu_div = 1'b0; c.per = 1'b1; end
            default:  begin c.cpu_full = 1'b0; c.cpu_div = 1'b0; c.per = 1'b0; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
    import lpm_pkg::*;
#(
    parameter int W = WAKE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wake_req,
    input  logic [W-1:0] wake_en,
    input  logic         irq_mask,
    input  logic         cfg_lson,
    input  mode_e        cur_mode,
    output logic         wake_go
);

    logic [W-1:0] req_q;
    logic [W-1:0] en_q;
    logic         mask_q;
    logic [W-1:0] elig;
    logic [W-1:0] pend;
    logic         state_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            en_q   <= '0;
            mask_q <= 1'b1;
        end else begin
            req_q  <= wake_req;
            en_q   <= wake_en;
            mask_q <= irq_mask;
        end
    end

    assign elig = wake_set_for(cur_mode);

    for (genvar i = 0; i < W; i++) begin : g_src
        assign pend[i] = req_q[i] & en_q[i] & elig[i];
    end

    assign state_ok = (cur_mode == M_SUBSLP) || ((cur_mode == M_WATCH) && cfg_lson);
    assign wake_go  = state_ok && !mask_q && (|pend);

endmodule

// File: rtl/lpm_sleep_dec.sv
module lpm_sleep_dec
    import lpm_pkg::*;
(
    input  logic  sleep_req,
    input  logic  cfg_stby,
    input  logic  cfg_lson,
    input  logic  cfg_tmsrc,
    input  mode_e cur_mode,
    output logic  go,
    output mode_e target,
    output logic  illegal
);

    logic active_req;
    logic to_watch;
    logic to_subslp;

    always_comb begin
        active_req = sleep_req && (cur_mode == M_SUBACT);
        to_watch   = cfg_stby && cfg_tmsrc;
        to_subslp  = !cfg_stby && cfg_lson && cfg_tmsrc;
        go         = active_req && (to_watch || to_subslp);
        illegal    = active_req && !(to_watch || to_subslp);
        target     = to_watch ? M_WATCH : M_SUBSLP;
    end

endmodule

// File: rtl/lpm_subclk_div.sv
module lpm_subclk_div
    import lpm_pkg::*;
#(
    parameter int CNT_W = DIV_CNT_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic       latch_en,
    input  logic [1:0] cfg_div,
    output logic [1:0] div_sel,
    output logic       tick
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    assign last = div_last(div_sel);
    assign tick = run && (cnt >= last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_sel <= 2'b00;
        end else if (latch_en) begin
            div_sel <= cfg_div;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int NSRC = WAKE_W
) (
    input  logic            clk,
    input  logic            rst_pin_n,
    input  logic            sleep_req,
    input  logic            cfg_stby,
    input  logic            cfg_lson,
    input  logic            cfg_tmsrc,
    input  logic [1:0]      cfg_div,
    input  logic [NSRC-1:0] wake_req,
    input  logic [NSRC-1:0] wake_en,
    input  logic            irq_mask,
    input  logic            tst_load,
    input  logic [1:0]      tst_mode,
    output logic [1:0]      mode,
    output logic            cpu_clk_en,
    output logic            per_clk_en,
    output logic            wtmr_clk_en,
    output logic [1:0]      div_sel,
    output logic            illegal_sleep
);

    mode_e     state;
    mode_e     nxt;
    mode_e     dec_target;
    logic      dec_go;
    logic      dec_illegal;
    logic      wake_go;
    logic      div_tick;
    logic      div_run;
    logic      div_latch;
    clk_plan_t plan;

    lpm_wake_qual #(.W(NSRC)) u_wake (
        .clk      (clk),
        .rst_n    (rst_pin_n),
        .wake_req (wake_req),
        .wake_en  (wake_en),
        .irq_mask (irq_mask),
        .cfg_lson (cfg_lson),
        .cur_mode (state),
        .wake_go  (wake_go)
    );

    lpm_sleep_dec u_dec (
        .sleep_req (sleep_req),
        .cfg_stby  (cfg_stby),
        .cfg_lson  (cfg_lson),
        .cfg_tmsrc (cfg_tmsrc),
        .cur_mode  (state),
        .go        (dec_go),
        .target    (dec_target),
        .illegal   (dec_illegal)
    );

    assign div_run   = (state == M_SUBACT);
    assign div_latch = (state == M_SUBACT) || (state == M_ACTIVE);

    lpm_subclk_div u_div (
        .clk      (clk),
        .rst_n    (rst_pin_n),
        .run      (div_run),
        .restart  (tst_load),
        .latch_en (div_latch),
        .cfg_div  (cfg_div),
        .div_sel  (div_sel),
        .tick     (div_tick)
    );

    always_comb begin
        nxt = state;
        if (state == M_SUBACT && dec_go)
            nxt = dec_target;
        else if ((state == M_SUBSLP || state == M_WATCH) && wake_go)
            nxt = M_SUBACT;
    end

    always_ff @(posedge clk) begin
        if (!rst_pin_n) begin
            state         <= M_ACTIVE;
            illegal_sleep <= 1'b0;
        end else if (tst_load) begin
            state         <= mode_e'(tst_mode);
            illegal_sleep <= 1'b0;
        end else begin
            state         <= nxt;
            illegal_sleep <= dec_illegal;
        end
    end

    assign plan        = clocks_for(state);
    assign mode        = state;
    assign cpu_clk_en  = plan.cpu_full | (plan.cpu_div & div_tick);
    assign per_clk_en  = plan.per;
    assign wtmr_clk_en = plan.wtmr;

endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk
    import lpm_pkg::*;
(
    input logic              clk,
    input logic              rst_pin_n,
    input logic              sleep_req,
    input logic              cfg_stby,
    input logic              cfg_lson,
    input logic              cfg_tmsrc,
    input logic [WAKE_W-1:0] wake_req,
    input logic [WAKE_W-1:0] wake_en,
    input logic              irq_mask,
    input logic              tst_load,
    input logic [1:0]        mode,
    input logic              cpu_clk_en,
    input logic              per_clk_en,
    input logic              wtmr_clk_en,
    input logic              illegal_sleep
);

    localparam logic [WAKE_W-1:0] WSET = wake_set_for(M_WATCH);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_pin_n |=> (mode == 2'd0 && !illegal_sleep));

    // R2
    watch_wake_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        ($past(rst_pin_n) && mode == 2'd3 && cfg_lson && !tst_load &&
         !$past(irq_mask) && (|($past(wake_req & wake_en) & WSET)))
        |=> (mode == 2'd1));

    // R3
    watch_lson_off_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (mode == 2'd3 && !cfg_lson && !tst_load) |=> (mode == 2'd3));

    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        ($past(rst_pin_n) && $past(irq_mask) && mode == 2'd2 && !tst_load)
        |=> (mode == 2'd2));

    // R6
    sleep_watch_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (mode == 2'd1 && sleep_req && cfg_stby && cfg_tmsrc && !tst_load)
        |=> (mode == 2'd3));

    // R7
    sleep_subslp_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (mode == 2'd1 && sleep_req && !cfg_stby && cfg_lson && cfg_tmsrc && !tst_load)
        |=> (mode == 2'd2));

    // R8
    illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        illegal_sleep |=> !illegal_sleep);

    // R8
    illegal_stay_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (mode == 2'd1 && sleep_req && !tst_load &&
         !(cfg_stby && cfg_tmsrc) && !(!cfg_stby && cfg_lson && cfg_tmsrc))
        |=> (mode == 2'd1 && illegal_sleep));

    // R10
    watch_clocks_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (mode == 2'd3) |-> (!cpu_clk_en && !per_clk_en && wtmr_clk_en));

    // R10
    subslp_clocks_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (mode == 2'd2) |-> (!cpu_clk_en && per_clk_en && wtmr_clk_en));

endmodule

bind lpm_seq lpm_seq_chk u_chk (.*);

// File: tb/lpm_seq_bench.sv
module lpm_seq_bench;

    localparam int NW = 19;

    logic          clk = 1'b0;
    logic          rst_pin_n;
    logic          sleep_req;
    logic          cfg_stby;
    logic          cfg_lson;
    logic          cfg_tmsrc;
    logic [1:0]    cfg_div;
    logic [NW-1:0] wake_req;
    logic [NW-1:0] wake_en;
    logic          irq_mask;
    logic          tst_load;
    logic [1:0]    tst_mode;
    logic [1:0]    mode;
    logic          cpu_clk_en;
    logic          per_clk_en;
    logic          wtmr_clk_en;
    logic [1:0]    div_sel;
    logic          illegal_sleep;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    localparam logic [1:0] ACT = 2'd0, SUB = 2'd1, SSL = 2'd2, WAT = 2'd3;

    always #4 clk = ~clk;

    lpm_seq u_lpm_seq (
        .clk(clk), .rst_pin_n(rst_pin_n), .sleep_req(sleep_req),
        .cfg_stby(cfg_stby), .cfg_lson(cfg_lson), .cfg_tmsrc(cfg_tmsrc),
        .cfg_div(cfg_div), .wake_req(wake_req), .wake_en(wake_en),
        .irq_mask(irq_mask), .tst_load(tst_load), .tst_mode(tst_mode),
        .mode(mode), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .wtmr_clk_en(wtmr_clk_en), .div_sel(div_sel), .illegal_sleep(illegal_sleep)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        sleep_req = 0; cfg_stby = 0; cfg_lson = 0; cfg_tmsrc = 0;
        wake_req = '0; wake_en = '0; irq_mask = 0; tst_load = 0; tst_mode = ACT;
    endtask

    task automatic load_mode(input logic [1:0] m);
        wake_req = '0; sleep_req = 0;
        tst_load = 1; tst_mode = m;
        step();
        tst_load = 0;
    endtask

    task automatic t_reset_state();
        rst_pin_n = 0;
        idle_inputs();
        cfg_div = 2'b00;
        step(); step();
        check("R1 mode in reset", mode, ACT);
        check("R1 illegal in reset", illegal_sleep, 0);
        rst_pin_n = 1;
        step();
        check("R10 active cpu en", cpu_clk_en, 1);
        check("R10 active per en", per_clk_en, 1);
        check("R10 active wtmr en", wtmr_clk_en, 1);
        // R1: ACTIVE ignores sleep and wake
        sleep_req = 1; cfg_stby = 1; cfg_tmsrc = 1;
        wake_req = '1; wake_en = '1;
        step(); sleep_req = 0; step(); step();
        check("R1 active ignores sleep/wake", mode, ACT);
        check("R1 active no illegal flag", illegal_sleep, 0);
        idle_inputs();
        step();
    endtask

    task automatic t_watch_wake();
        for (int i = 0; i < 12; i++) begin
            load_mode(WAT);
            cfg_lson = 1; wake_en = '1; irq_mask = 0;
            wake_req = '0; wake_req[i] = 1'b1;
            step();
            check($sformatf("R2 watch held after first edge src %0d", i), mode, WAT);
            step();
            check($sformatf("R2 watch wake src %0d", i), mode, SUB);
        end
        idle_inputs();
    endtask

    task automatic t_watch_blocked();
        for (int i = 12; i < NW; i++) begin
            load_mode(WAT);
            cfg_lson = 1; wake_en = '1;
            wake_req = '0; wake_req[i] = 1'b1;
            step(); step(); step();
            check($sformatf("R3 watch ignores ext src %0d", i), mode, WAT);
        end
        load_mode(WAT);
        cfg_lson = 0; wake_en = '1; wake_req = '1;
        step(); step(); step();
        check("R3 watch ignores wake with lson=0", mode, WAT);
        check("R10 watch cpu en", cpu_clk_en, 0);
        check("R10 watch per en", per_clk_en, 0);
        check("R10 watch wtmr en", wtmr_clk_en, 1);
        idle_inputs();
    endtask

    task automatic t_subslp_wake();
        for (int i = 0; i < NW; i++) begin
            load_mode(SSL);
            wake_en = '1;
            wake_req = '0; wake_req[i] = 1'b1;
            step();
            check($sformatf("R4 subsleep held after first edge src %0d", i), mode, SSL);
            step();
            check($sformatf("R4 subsleep wake src %0d", i), mode, SUB);
        end
        load_mode(SSL);
        check("R10 subsleep cpu en", cpu_clk_en, 0);
        check("R10 subsleep per en", per_clk_en, 1);
        idle_inputs();
    endtask

    task automatic t_mask_enable();
        load_mode(SSL);
        irq_mask = 1; wake_en = '1; wake_req = '1;
        step(); step(); step();
        check("R5 masked wake ignored", mode, SSL);
        irq_mask = 0; wake_en = '0;
        step(); step(); step();
        check("R5 disabled wake ignored", mode, SSL);
        wake_req = '0; wake_req[5] = 1'b1;
        wake_en = '0; wake_en[6] = 1'b1;
        step(); step(); step();
        check("R5 enable on other source ignored", mode, SSL);
        wake_en[5] = 1'b1;
        step(); step();
        check("R5 enabled source wakes", mode, SUB);
        idle_inputs();
    endtask

    task automatic t_sleep_targets();
        load_mode(SUB);
        cfg_stby = 1; cfg_lson = 0; cfg_tmsrc = 1; sleep_req = 1;
        step(); sleep_req = 0;
        check("R6 sleep to watch", mode, WAT);
        check("R6 no illegal flag", illegal_sleep, 0);
        load_mode(SUB);
        cfg_stby = 1; cfg_lson = 1; cfg_tmsrc = 1; sleep_req = 1;
        step(); sleep_req = 0;
        check("R6 sleep to watch with lson=1", mode, WAT);
        load_mode(SUB);
        cfg_stby = 0; cfg_lson = 1; cfg_tmsrc = 1; sleep_req = 1;
        step(); sleep_req = 0;
        check("R7 sleep to subsleep", mode, SSL);
        check("R7 no illegal flag", illegal_sleep, 0);
        idle_inputs();
    endtask

    task automatic t_illegal();
        for (int c = 0; c < 8; c++) begin
            logic s, l, t;
            s = c[2]; l = c[1]; t = c[0];
            if ((s && t) || (!s && l && t)) continue;
            load_mode(SUB);
            cfg_stby = s; cfg_lson = l; cfg_tmsrc = t; sleep_req = 1;
            step(); sleep_req = 0;
            check($sformatf("R8 stay subactive combo %0d", c), mode, SUB);
            check($sformatf("R8 illegal raised combo %0d", c), illegal_sleep, 1);
            step();
            check($sformatf("R8 illegal one cycle combo %0d", c), illegal_sleep, 0);
        end
        idle_inputs();
    endtask

    task automatic t_divider(input logic [1:0] code, input int ratio);
        int count;
        int first;
        load_mode(ACT);
        cfg_div = code;
        step();
        check($sformatf("R9 div_sel captured code %0d", code), div_sel, code);
        load_mode(SUB);
        count = 0; first = -1;
        for (int i = 0; i < 24; i++) begin
            if (cpu_clk_en) begin
                count++;
                if (first < 0) first = i;
            end
            step();
        end
        check($sformatf("R9 pulse count code %0d", code), count, 24 / ratio);
        check($sformatf("R9 first pulse code %0d", code), first, ratio - 1);
    endtask

    task automatic t_reset_from_low_power();
        load_mode(SUB);
        rst_pin_n = 0;
        step();
        check("R11 reset leaves subactive", mode, ACT);
        tst_load = 1; tst_mode = WAT; sleep_req = 1; cfg_stby = 1; cfg_tmsrc = 1;
        step(); step();
        check("R11 held in ACTIVE during reset", mode, ACT);
        check("R11 no illegal during reset", illegal_sleep, 0);
        idle_inputs();
        rst_pin_n = 1;
        load_mode(WAT);
        rst_pin_n = 0;
        step();
        check("R11 reset leaves watch", mode, ACT);
        rst_pin_n = 1;
        step();
    endtask

    task automatic t_load();
        for (int m = 0; m < 4; m++) begin
            load_mode(m[1:0]);
            check($sformatf("R12 load mode %0d", m), mode, m);
        end
        load_mode(SUB);
        cfg_stby = 1; cfg_tmsrc = 1; sleep_req = 1;
        tst_load = 1; tst_mode = SSL;
        step();
        tst_load = 0; sleep_req = 0;
        check("R12 load overrides sleep", mode, SSL);
        idle_inputs();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_pin_n = 0;
        idle_inputs();
        cfg_div = 2'b00;
        t_reset_state();
        t_watch_wake();
        t_watch_blocked();
        t_subslp_wake();
        t_mask_enable();
        t_sleep_targets();
        t_illegal();
        t_divider(2'b00, 8);
        t_divider(2'b01, 4);
        t_divider(2'b10, 2);
        t_divider(2'b11, 2);
        t_reset_from_low_power();
        t_load();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule